// File: doc/BRIEF.md
# SPI Status and Request Controller

This block sits beside the shift engine and the two FIFOs of a SPI peripheral and turns what they report into status, interrupt and DMA signalling. The shift engine delivers one-cycle event pulses (word done, frame done, transfer done, transmit underrun, receive overrun, data match) and a live busy level. The FIFOs deliver only their occupancy counts. The block latches the events as sticky flags, derives two level flags by comparing the occupancy counts with programmable watermarks, and reports all of this through a small register interface.

Software clears the sticky flags with write-one-to-clear writes. It enables interrupt sources per flag and enables DMA per direction. For each direction, a fill or drain request is serviced either by the interrupt or by DMA, never both: setting the interrupt enable for that direction masks its DMA request. Watermark writes are cut down to the bit width of the FIFO depth instead of being refused. The FIFO depths are readable as power-of-two exponents, and the current occupancy counts are readable as well.

Register reads are combinational on `regAddr`. A write takes effect at the clock edge where `regWrEn` is high.

Top module: `spi_stat_req_ctrl`

## Requirements
- R1: After reset the sticky flags, the interrupt enables, the DMA enables and both watermarks are zero, and `irqOut`, `txDmaReq` and `rxDmaReq` are low.
- R2: The status register is at address 0. A pulse on word done, frame done, transfer done, underrun, overrun or match sets status bit 2, 3, 4, 5, 6 or 7 respectively at the next clock edge. The bit then stays set until it is cleared.
- R3: A write to address 0 clears each sticky bit whose data bit is 1. Data bits that are 0 leave their flags unchanged. A write of 0x1FF clears every sticky flag at once.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Status bit 0 (transmit request) is high while the transmit count is less than or equal to the transmit watermark. It is a level and is not affected by writes to address 0.
- R6: Status bit 1 (receive ready) is high while the receive count is strictly greater than the receive watermark.
- R7: Status bit 8 mirrors `busyIn` in the same cycle and cannot be cleared by a write.
- R8: Address 1 holds 8 interrupt enables, one for each of status bits 0..7. `irqOut` is high exactly when some status bit 0..7 is set and its enable is set.
- R9: Address 2 holds the DMA enables: bit 0 for transmit and bit 1 for receive. `txDmaReq` equals transmit request AND DMA bit 0 AND NOT interrupt enable bit 0. `rxDmaReq` equals receive ready AND DMA bit 1 AND NOT interrupt enable bit 1.
- R10: Address 3 holds the transmit watermark in bits [7:0] and the receive watermark in bits [23:16]. A written value keeps only its low exponent-wide bits, and reads return the truncated value.
- R11: Address 4 reads the transmit count in [7:0] and the receive count in [23:16]. Address 5 reads the transmit depth exponent in [7:0] and the receive depth exponent in [15:8]. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| txCount | input | TX_EXP+1 | Transmit FIFO occupancy |
| rxCount | input | RX_EXP+1 | Receive FIFO occupancy |
| evWordDone | input | 1 | Word completed pulse |
| evFrameDone | input | 1 | Frame completed pulse |
| evXferDone | input | 1 | Transfer completed pulse |
| evTxUnderrun | input | 1 | Transmit underrun pulse |
| evRxOverrun | input | 1 | Receive overrun pulse |
| evDataMatch | input | 1 | Data match pulse |
| busyIn | input | 1 | Live busy level from the shift engine |
| irqOut | output | 1 | Interrupt request |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |

## Verification
Each of the six sticky flags is a single register. A flag that is set or cleared wrongly shows up at the next read of address 0, and also on `irqOut` in the first cycle after the offending edge whenever its enable is on. A corrupted enable or watermark register is visible just as quickly: the watermark readback changes, and the transmit request, receive ready and DMA outputs flip within the same cycle once the counts cross the threshold. The bench therefore compares every output against a reference model in every cycle, instead of only at selected points.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int NUM_EVT = 6;
  // first sticky bit inside the status word
  localparam int EVT_LSB = 2;
  localparam int BUSY_BIT = EVT_LSB + NUM_EVT;
  localparam int NUM_IRQ_SRC = BUSY_BIT;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STATUS = 3'd0,
    ADDR_INTEN  = 3'd1,
    ADDR_DMAEN  = 3'd2,
    ADDR_WATER  = 3'd3,
    ADDR_LEVEL  = 3'd4,
    ADDR_PARAM  = 3'd5
  } regAddr_e;

  typedef struct packed {
    logic              clrStb;
    logic              ienStb;
    logic              denStb;
    logic              wmStb;
    logic [DATA_W-1:0] data;
  } regStrobes_t;

endpackage

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output regStrobes_t       strb
);

  always_comb begin
    strb        = '0;
    strb.data   = regWrData;
    if (regWrEn) begin
      case (regAddr)
        ADDR_STATUS: strb.clrStb = 1'b1;
        ADDR_INTEN:  strb.ienStb = 1'b1;
        ADDR_DMAEN:  strb.denStb = 1'b1;
        ADDR_WATER:  strb.wmStb  = 1'b1;
        default:     ;
      endcase
    end
  end

  always_comb begin
    assert_single_strobe_R3: assert ($onehot0({strb.clrStb, strb.ienStb, strb.denStb, strb.wmStb}));
  end

endmodule

// File: rtl/spi_stat_dp.sv
module spi_stat_dp
  import spi_stat_pkg::*;
#(
  parameter int TX_EXP = 2,
  parameter int RX_EXP = 2,
  localparam int TX_CNT_W = TX_EXP + 1,
  localparam int RX_CNT_W = RX_EXP + 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  regStrobes_t         strb,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [TX_CNT_W-1:0] txCount,
  input  logic [RX_CNT_W-1:0] rxCount,
  input  logic [NUM_EVT-1:0]  evPulse,
  input  logic                busyIn,
  output logic [DATA_W-1:0]   regRdData,
  output logic                irqOut,
  output logic                txDmaReq,
  output logic                rxDmaReq
);

  logic [NUM_EVT-1:0]     sticky;
  logic [NUM_IRQ_SRC-1:0] intEn;
  logic [1:0]             dmaEn;
  logic [TX_EXP-1:0]      txWater;
  logic [RX_EXP-1:0]      rxWater;
  logic                   txReq;
  logic                   rxRdy;
  logic [NUM_IRQ_SRC-1:0] srcVec;

  // sticky event flags, set has priority over clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)
        sticky[i] <= 1'b0;
      else if (evPulse[i])
        sticky[i] <= 1'b1;
      else if (strb.clrStb && strb.data[EVT_LSB+i])
        sticky[i] <= 1'b0;
    end

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
      (evPulse[i] && strb.clrStb && strb.data[EVT_LSB+i]) |=> sticky[i]);
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!evPulse[i] && strb.clrStb && strb.data[EVT_LSB+i]) |=> !sticky[i]);
    assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!evPulse[i] && !(strb.clrStb && strb.data[EVT_LSB+i])) |=> $stable(sticky[i]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn   <= '0;
      dmaEn   <= '0;
      txWater <= '0;
      rxWater <= '0;
    end else begin
      if (strb.ienStb) intEn <= strb.data[NUM_IRQ_SRC-1:0];
      if (strb.denStb) dmaEn <= strb.data[1:0];
      if (strb.wmStb) begin
        txWater <= strb.data[TX_EXP-1:0];
        rxWater <= strb.data[16 +: RX_EXP];
      end
    end
  end

  assert_water_trunc_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.wmStb |=> (txWater == $past(strb.data[TX_EXP-1:0])) &&
                   (rxWater == $past(strb.data[16 +: RX_EXP])));

  // level flags from occupancy
  assign txReq = (txCount <= TX_CNT_W'(txWater));
  assign rxRdy = (rxCount >  RX_CNT_W'(rxWater));

  assign srcVec   = {sticky, rxRdy, txReq};
  assign irqOut   = |(srcVec & intEn);
  assign txDmaReq = txReq & dmaEn[0] & ~intEn[0];
  assign rxDmaReq = rxRdy & dmaEn[1] & ~intEn[1];

  assert_tx_dma_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    intEn[0] |-> !txDmaReq);
  assert_rx_dma_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    intEn[1] |-> !rxDmaReq);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_STATUS: regRdData[BUSY_BIT:0]        = {busyIn, srcVec};
      ADDR_INTEN:  regRdData[NUM_IRQ_SRC-1:0]   = intEn;
      ADDR_DMAEN:  regRdData[1:0]               = dmaEn;
      ADDR_WATER: begin
        regRdData[TX_EXP-1:0]    = txWater;
        regRdData[16 +: RX_EXP]  = rxWater;
      end
      ADDR_LEVEL: begin
        regRdData[TX_CNT_W-1:0]  = txCount;
        regRdData[16 +: RX_CNT_W] = rxCount;
      end
      ADDR_PARAM: begin
        regRdData[7:0]  = 8'(TX_EXP);
        regRdData[15:8] = 8'(RX_EXP);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/spi_stat_req_ctrl.sv
module spi_stat_req_ctrl
  import spi_stat_pkg::*;
#(
  parameter int TX_EXP = 2,
  parameter int RX_EXP = 2,
  localparam int TX_CNT_W = TX_EXP + 1,
  localparam int RX_CNT_W = RX_EXP + 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [TX_CNT_W-1:0] txCount,
  input  logic [RX_CNT_W-1:0] rxCount,
  input  logic                evWordDone,
  input  logic                evFrameDone,
  input  logic                evXferDone,
  input  logic                evTxUnderrun,
  input  logic                evRxOverrun,
  input  logic                evDataMatch,
  input  logic                busyIn,
  output logic                irqOut,
  output logic                txDmaReq,
  output logic                rxDmaReq
);

  regStrobes_t        strb;
  logic [NUM_EVT-1:0] evPulse;

  assign evPulse = {evDataMatch, evRxOverrun, evTxUnderrun,
                    evXferDone, evFrameDone, evWordDone};

  spi_stat_ctrl u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb)
  );

  spi_stat_dp #(.TX_EXP(TX_EXP), .RX_EXP(RX_EXP)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regAddr   (regAddr),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .evPulse   (evPulse),
    .busyIn    (busyIn),
    .regRdData (regRdData),
    .irqOut    (irqOut),
    .txDmaReq  (txDmaReq),
    .rxDmaReq  (rxDmaReq)
  );

endmodule

// File: tb/sim_spi_stat_req_ctrl.sv
module sim_spi_stat_req_ctrl;

  localparam int TXE = 2;
  localparam int RXE = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [2:0]  txCount = '0;
  logic [2:0]  rxCount = '0;
  logic        evWordDone = 0, evFrameDone = 0, evXferDone = 0;
  logic        evTxUnderrun = 0, evRxOverrun = 0, evDataMatch = 0;
  logic        busyIn = 1'b0;
  logic        irqOut, txDmaReq, rxDmaReq;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  // reference model state
  logic [5:0] mSticky = '0;
  logic [7:0] mIen = '0;
  logic [1:0] mDen = '0;
  logic [1:0] mTxW = '0;
  logic [1:0] mRxW = '0;

  always #2 clk = ~clk;

  spi_stat_req_ctrl #(.TX_EXP(TXE), .RX_EXP(RXE)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .txCount(txCount),
    .rxCount(rxCount), .evWordDone(evWordDone), .evFrameDone(evFrameDone),
    .evXferDone(evXferDone), .evTxUnderrun(evTxUnderrun),
    .evRxOverrun(evRxOverrun), .evDataMatch(evDataMatch), .busyIn(busyIn),
    .irqOut(irqOut), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  function automatic logic [7:0] srcBits(input int txc, input int rxc);
    return {mSticky, (rxc > int'(mRxW)), (txc <= int'(mTxW))};
  endfunction

  function automatic logic [31:0] expRead(input logic [2:0] a, input int txc,
                                          input int rxc, input logic bz);
    logic [31:0] r = '0;
    case (a)
      3'd0: r[8:0] = {bz, srcBits(txc, rxc)};
      3'd1: r[7:0] = mIen;
      3'd2: r[1:0] = mDen;
      3'd3: begin r[1:0] = mTxW; r[17:16] = mRxW; end
      3'd4: begin r[2:0] = txc[2:0]; r[18:16] = rxc[2:0]; end
      3'd5: begin r[7:0] = 8'(TXE); r[15:8] = 8'(RXE); end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string readTag(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R8";
      3'd2: return "R9";
      3'd3: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] a, input logic we, input logic [31:0] wd,
                      input int txc, input int rxc, input logic [5:0] ev,
                      input logic bz, input string tag);
    logic [7:0] s;
    @(negedge clk);
    regAddr = a; regWrEn = we; regWrData = wd;
    txCount = txc[2:0]; rxCount = rxc[2:0]; busyIn = bz;
    {evDataMatch, evRxOverrun, evTxUnderrun, evXferDone, evFrameDone, evWordDone} = ev;
    #1;
    s = srcBits(txc, rxc);
    check(regRdData, expRead(a, txc, rxc, bz), (tag == "") ? readTag(a) : tag, "read");
    check({31'b0, irqOut}, {31'b0, |(s & mIen)}, "R8", "irqOut");
    check({31'b0, txDmaReq}, {31'b0, s[0] & mDen[0] & ~mIen[0]}, "R9", "txDmaReq");
    check({31'b0, rxDmaReq}, {31'b0, s[1] & mDen[1] & ~mIen[1]}, "R9", "rxDmaReq");
    // model next state
    if (we && a == 3'd0) mSticky = mSticky & ~wd[7:2];
    mSticky = mSticky | ev;
    if (we && a == 3'd1) mIen = wd[7:0];
    if (we && a == 3'd2) mDen = wd[1:0];
    if (we && a == 3'd3) begin mTxW = wd[1:0]; mRxW = wd[17:16]; end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: reset state
    step(3'd0, 0, 0, 4, 0, 6'h00, 0, "R1");
    step(3'd1, 0, 0, 4, 0, 6'h00, 0, "R1");
    step(3'd3, 0, 0, 4, 0, 6'h00, 0, "R1");
    // R2: every event latches
    step(3'd0, 0, 0, 4, 0, 6'h3F, 0, "R2");
    step(3'd0, 0, 0, 4, 0, 6'h00, 0, "R2");
    // R3: writing zero keeps flags, clear-all clears
    step(3'd0, 1, 32'h0, 4, 0, 6'h00, 0, "R3");
    step(3'd0, 0, 0, 4, 0, 6'h00, 0, "R3");
    step(3'd0, 1, 32'h1FF, 4, 0, 6'h00, 0, "R3");
    step(3'd0, 0, 0, 4, 0, 6'h00, 0, "R3");
    // R4: set wins against clear
    step(3'd0, 1, 32'h4, 4, 0, 6'h01, 0, "R4");
    step(3'd0, 0, 0, 4, 0, 6'h00, 0, "R4");
    // R5: level request unaffected by write-one
    step(3'd0, 1, 32'h1, 0, 0, 6'h00, 0, "R5");
    step(3'd0, 0, 0, 0, 0, 6'h00, 0, "R5");
    // R10: truncation
    step(3'd3, 1, 32'h00FF_00FF, 4, 0, 6'h00, 0, "R10");
    step(3'd3, 0, 0, 4, 0, 6'h00, 0, "R10");
    // R5 / R6 boundaries at watermark 3
    step(3'd0, 0, 0, 3, 3, 6'h00, 0, "R5");
    step(3'd0, 0, 0, 4, 3, 6'h00, 0, "R6");
    step(3'd0, 0, 0, 4, 4, 6'h00, 0, "R6");
    // R7: busy mirrors and ignores clear
    step(3'd0, 1, 32'h100, 4, 0, 6'h00, 1, "R7");
    step(3'd0, 0, 0, 4, 0, 6'h00, 1, "R7");
    // R8: single enabled source drives irq
    step(3'd1, 1, 32'h04, 4, 0, 6'h00, 0, "R8");
    step(3'd0, 0, 0, 4, 0, 6'h00, 0, "R8");
    // R9: dma then suppression by interrupt enable
    step(3'd2, 1, 32'h3, 0, 4, 6'h00, 0, "R9");
    step(3'd1, 1, 32'h00, 0, 4, 6'h00, 0, "R9");
    step(3'd1, 1, 32'h03, 0, 4, 6'h00, 0, "R9");
    step(3'd2, 0, 0, 0, 4, 6'h00, 0, "R9");
    // R11: depth and level readback
    step(3'd5, 0, 0, 2, 1, 6'h00, 0, "R11");
    step(3'd4, 0, 0, 2, 1, 6'h00, 0, "R11");
    step(3'd6, 0, 0, 2, 1, 6'h00, 0, "R11");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  a  = 3'($urandom % 8);
      logic        we = (($urandom % 4) == 0);
      logic [31:0] wd = $urandom;
      logic [5:0]  ev = 6'($urandom & $urandom);
      step(a, we, wd, int'($urandom % 5), int'($urandom % 5), ev,
           1'($urandom), "");
    end
    finishRun();
  end

endmodule